// File: doc/BRIEF.md
# Bit-Serial CRC Generator and Checker

This block computes a cyclic redundancy code one bit per clock by long division over GF(2). The register holds the running remainder. Each accepted bit is shifted in at the low end. When the bit shifted out at the top is 1, the low coefficients of the generator are XORed into the register. A parameter picks the generator: the degree-4 polynomial x^4+x+1, the 16-bit code x^16+x^15+x^2+1, or the 32-bit code x^32+x^26+x^23+x^22+x^16+x^12+x^11+x^10+x^8+x^7+x^5+x^4+x^2+x+1. A second parameter picks the starting register value. It is all zeros by default and all ones for the 32-bit code.

A run begins with a start strobe, which also latches the mode. In generate mode the caller shifts in the message, most significant bit first, and marks the final bit. The block then feeds N zero bits by itself, so the remainder left is M(x)·x^N mod G(x). The sender transmits that remainder in place of the zeros. In check mode the caller shifts in the whole received codeword. No zeros are appended, and the block flags whether the remainder is zero. With a non-zero starting value, generate and check add the same term to the result, because both shift the same number of bits. A codeword built by this block therefore checks clean on a block configured the same way.

Top module: `crc_serial_engine`

## Requirements
- R1: After reset, crc_o is all zeros and done_o and zero_o are low.
- R2: A start strobe loads the starting value into the register on that edge: all zeros, or all ones for the 32-bit selection. It deasserts done_o. A start strobe during a run abandons the run.
- R3: In a shift phase, each edge with bit_valid_i high consumes bit_i, most significant bit first. The register shifts left with the bit entering at position 0, and the generator's low N coefficients are XORed in when the bit shifted out was 1. An edge with bit_valid_i low leaves the register unchanged.
- R4: mode_i = 0 selects generate. After the bit marked by bit_last_i, N zero bits are fed automatically, one per clock. done_o is high for one cycle, N cycles after the cycle in which it would rise in check mode. crc_o then holds the remainder, for example 1010 for message 1011001 under x^4+x+1.
- R5: mode_i = 1 selects check. done_o is high in the cycle right after the edge that accepts the last bit, and crc_o holds the codeword's remainder. zero_o is high in that cycle exactly when that remainder is zero. For example, 10110011010 gives 0000 and raises zero_o, and 10110011011 gives 0001.
- R6: POLY_SEL = 0, 1 and 2 select the degree-4, 16-bit and 32-bit generators. A codeword formed from a message and its generated remainder checks as zero with the same selection.
- R7: With the 16-bit generator, any single-bit error, any double-bit error, any odd number of flipped bits and any burst of 16 bits or less in a codeword leaves zero_o low at done.
- R8: bit_valid_i while no run is active has no effect: crc_o is unchanged and done_o stays low.
- R9: done_o never stays high for two consecutive cycles, and zero_o is high only together with done_o and never in generate mode.
- R10: After done_o, crc_o holds its value until the next start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a run: loads the starting value and latches mode_i |
| mode_i | input | 1 | 0 = generate, 1 = check; sampled with start_i |
| bit_valid_i | input | 1 | bit_i is presented this cycle |
| bit_i | input | 1 | Serial data bit, most significant bit first |
| bit_last_i | input | 1 | Marks the final message or codeword bit |
| crc_o | output | N | Remainder register (N = 4, 16 or 32) |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| zero_o | output | 1 | Check mode: remainder is zero, valid with done_o |

## Verification
The hardest behaviour to reach from the ports is the check of the 16-bit code's burst and multi-bit error guarantees, since it needs a codeword that is known to be correct. The stimulus gets there by first running generate mode on a message and taking the remainder from crc_o, then joining the two into a codeword. Chosen error masks are XORed into that codeword: one bit, two distant bits, three bits, and a 16-bit burst with both end bits set. The corrupted words are sent in check mode. The bench also restarts in the middle of a message and inserts valid-low gaps inside a message, to show that neither changes the result.

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_FLUSH = 2'd2
   } crc_state_e;

   typedef enum logic {
      MODE_GEN   = 1'b0,
      MODE_CHECK = 1'b1
   } crc_mode_e;

   // register width for each generator selection
   function automatic int unsigned crc_width(input int unsigned sel);
      case (sel)
         0:       return 4;
         1:       return 16;
         default: return 32;
      endcase
   endfunction

   // generator coefficients below the leading term
   function automatic logic [31:0] crc_taps(input int unsigned sel);
      case (sel)
         0:       return 32'h0000_0003;
         1:       return 32'h0000_8005;
         default: return 32'h04C1_1DB7;
      endcase
   endfunction

endpackage

// File: rtl/crc_div_step.sv
module crc_div_step #(
   parameter int unsigned W = 4,
   parameter logic [W-1:0] TAPS = '0
) (
   input  logic [W-1:0] rem_i,
   input  logic         bit_i,
   output logic [W-1:0] rem_o
);
   logic lead;
   assign lead = rem_i[W-1];

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic shifted;
      if (i == 0) begin : g_in
         assign shifted = bit_i;
      end else begin : g_mid
         assign shifted = rem_i[i-1];
      end
      if (TAPS[i]) begin : g_tap
         assign rem_o[i] = shifted ^ lead;
      end else begin : g_plain
         assign rem_o[i] = shifted;
      end
   end
endmodule

// File: rtl/crc_seq_ctrl.sv
module crc_seq_ctrl
   import crc_serial_pkg::*;
#(
   parameter int unsigned W = 4,
   localparam int unsigned CW = $clog2(W)
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  logic mode_i,
   input  logic bit_valid_i,
   input  logic bit_last_i,
   output logic step_o,
   output logic zero_feed_o,
   output logic fin_o,
   output logic fin_check_o
);
   crc_state_e    state_q;
   crc_mode_e     mode_q;
   logic [CW-1:0] cnt_q;
   logic          take_bit;
   logic          flush_end;

   assign take_bit  = (state_q == ST_SHIFT) && bit_valid_i && !start_i;
   assign flush_end = (state_q == ST_FLUSH) && (cnt_q == CW'(W-1)) && !start_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         mode_q  <= MODE_GEN;
         cnt_q   <= '0;
      end else if (start_i) begin
         state_q <= ST_SHIFT;
         mode_q  <= crc_mode_e'(mode_i);
         cnt_q   <= '0;
      end else begin
         case (state_q)
            ST_SHIFT: begin
               if (bit_valid_i && bit_last_i) begin
                  state_q <= (mode_q == MODE_CHECK) ? ST_IDLE : ST_FLUSH;
                  cnt_q   <= '0;
               end
            end
            ST_FLUSH: begin
               if (cnt_q == CW'(W-1)) state_q <= ST_IDLE;
               else                   cnt_q   <= cnt_q + 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign zero_feed_o = (state_q == ST_FLUSH) && !start_i;
   assign step_o      = take_bit || zero_feed_o;
   assign fin_check_o = take_bit && bit_last_i && (mode_q == MODE_CHECK);
   assign fin_o       = fin_check_o || flush_end;
endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine
   import crc_serial_pkg::*;
#(
   parameter int unsigned POLY_SEL  = 0,
   parameter bit          INIT_ONES = (POLY_SEL == 2),
   localparam int unsigned W        = crc_width(POLY_SEL)
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         start_i,
   input  logic         mode_i,
   input  logic         bit_valid_i,
   input  logic         bit_i,
   input  logic         bit_last_i,
   output logic [W-1:0] crc_o,
   output logic         done_o,
   output logic         zero_o
);
   localparam logic [31:0]  TAPS_ALL = crc_taps(POLY_SEL);
   localparam logic [W-1:0] TAPS     = TAPS_ALL[W-1:0];
   localparam logic [W-1:0] INIT_V   = {W{INIT_ONES}};

   if (POLY_SEL > 2) begin : g_bad_sel
      $error("crc_serial_engine: POLY_SEL must be 0, 1 or 2");
   end
   if (!TAPS[0]) begin : g_bad_taps
      $error("crc_serial_engine: generator needs a constant term");
   end

   logic         step, zero_feed, fin, fin_check;
   logic         flush_act;
   logic         feed_bit;
   logic [W-1:0] rem_q, rem_nxt;
   logic         done_q, zero_q;

   crc_seq_ctrl #(.W(W)) ctrl_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (start_i),
      .mode_i      (mode_i),
      .bit_valid_i (bit_valid_i),
      .bit_last_i  (bit_last_i),
      .step_o      (step),
      .zero_feed_o (zero_feed),
      .fin_o       (fin),
      .fin_check_o (fin_check)
   );

   assign feed_bit  = zero_feed ? 1'b0 : bit_i;
   assign flush_act = zero_feed;

   crc_div_step #(.W(W), .TAPS(TAPS)) step_i (
      .rem_i (rem_q),
      .bit_i (feed_bit),
      .rem_o (rem_nxt)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rem_q  <= '0;
         done_q <= 1'b0;
         zero_q <= 1'b0;
      end else begin
         done_q <= fin;
         zero_q <= fin_check && (rem_nxt == '0);
         if (start_i)   rem_q <= INIT_V;
         else if (step) rem_q <= rem_nxt;
      end
   end

   assign crc_o  = rem_q;
   assign done_o = done_q;
   assign zero_o = zero_q;
endmodule

// File: rtl/crc_serial_chk.sv
module crc_serial_chk #(
   parameter int unsigned W = 4,
   parameter logic [W-1:0] INIT_V = '0
) (
   input logic         clk_i,
   input logic         rst_ni,
   input logic         start_i,
   input logic         bit_valid_i,
   input logic         flush_act,
   input logic [W-1:0] crc_o,
   input logic         done_o,
   input logic         zero_o
);
   AST_START_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> (crc_o == INIT_V) && !done_o); // R2

   AST_HOLD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!start_i && !bit_valid_i && !flush_act) |=> $stable(crc_o)); // R8

   AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o); // R9

   AST_ZERO_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      zero_o |-> done_o); // R9

   AST_ZERO_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      zero_o |-> (crc_o == '0)); // R5
endmodule

bind crc_serial_engine crc_serial_chk #(.W(W), .INIT_V(INIT_V)) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .start_i     (start_i),
   .bit_valid_i (bit_valid_i),
   .flush_act   (flush_act),
   .crc_o       (crc_o),
   .done_o      (done_o),
   .zero_o      (zero_o)
);

// File: tb/crc_serial_engine_tb.sv
module crc_serial_engine_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, mode = 1'b0, valid = 1'b0, dbit = 1'b0, last = 1'b0;

   logic [3:0]  crc4;
   logic [15:0] crc16;
   logic [31:0] crc32;
   logic [2:0]  done_a, zero_a;
   logic [31:0] crc_a [3];

   int n_chk = 0, n_fail = 0;
   int ndone [3];
   int lat [3];
   logic [31:0] rrem [3];
   logic rzero [3];

   localparam int WA [3] = '{4, 16, 32};
   localparam logic [31:0] TA [3] = '{32'h3, 32'h8005, 32'h04C11DB7};
   localparam logic [31:0] IA [3] = '{32'h0, 32'h0, 32'hFFFF_FFFF};

   typedef struct packed {
      logic        md;
      logic [6:0]  len;
      logic [15:0] bits;
      logic [3:0]  rem;
      logic        zero;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{1'b0, 7'd7,  16'b1011001,     4'b1010, 1'b0},
      '{1'b1, 7'd11, 16'b10110011010, 4'b0000, 1'b1},
      '{1'b1, 7'd11, 16'b10110011011, 4'b0001, 1'b0},
      '{1'b0, 7'd1,  16'b1,           4'b0011, 1'b0},
      '{1'b0, 7'd4,  16'b0000,        4'b0000, 1'b0},
      '{1'b0, 7'd5,  16'b10011,       4'b0000, 1'b0},
      '{1'b1, 7'd5,  16'b10011,       4'b0000, 1'b1},
      '{1'b0, 7'd2,  16'b11,          4'b0101, 1'b0}
   };

   always #5ns clk = ~clk;

   crc_serial_engine #(.POLY_SEL(0)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
      .bit_valid_i(valid), .bit_i(dbit), .bit_last_i(last),
      .crc_o(crc4), .done_o(done_a[0]), .zero_o(zero_a[0]));
   crc_serial_engine #(.POLY_SEL(1)) dut16_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
      .bit_valid_i(valid), .bit_i(dbit), .bit_last_i(last),
      .crc_o(crc16), .done_o(done_a[1]), .zero_o(zero_a[1]));
   crc_serial_engine #(.POLY_SEL(2)) dut32_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
      .bit_valid_i(valid), .bit_i(dbit), .bit_last_i(last),
      .crc_o(crc32), .done_o(done_a[2]), .zero_o(zero_a[2]));

   assign crc_a[0] = {28'b0, crc4};
   assign crc_a[1] = {16'b0, crc16};
   assign crc_a[2] = crc32;

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_rem(input int k, input logic [63:0] msg,
                                           input int len, input bit gen);
      logic [31:0] r, mask;
      logic lead;
      mask = (WA[k] == 32) ? 32'hFFFF_FFFF : ((32'h1 << WA[k]) - 1);
      r = IA[k] & mask;
      for (int i = len - 1; i >= -(gen ? WA[k] : 0); i--) begin
         lead = r[WA[k]-1];
         r = ((r << 1) | ((i >= 0) ? {31'b0, msg[i]} : 32'b0)) & mask;
         if (lead) r = r ^ (TA[k] & mask);
      end
      return r;
   endfunction

   task automatic run_msg(input logic md, input logic [63:0] msg,
                          input int len, input bit gaps);
      for (int k = 0; k < 3; k++) begin
         ndone[k] = 0; lat[k] = 0; rrem[k] = '0; rzero[k] = 1'b0;
      end
      @(negedge clk); start = 1'b1; mode = md; valid = 1'b0; last = 1'b0;
      @(negedge clk); start = 1'b0;
      for (int i = len - 1; i >= 0; i--) begin
         if (gaps && (i % 3 == 1)) begin
            valid = 1'b0; last = 1'b0; dbit = ~msg[i]; @(negedge clk);
         end
         valid = 1'b1; dbit = msg[i]; last = (i == 0); @(negedge clk);
      end
      valid = 1'b0; last = 1'b0; dbit = 1'b0;
      for (int c = 1; c <= 40; c++) begin
         for (int k = 0; k < 3; k++) begin
            if (done_a[k]) begin
               if (ndone[k] == 0) begin
                  lat[k] = c; rrem[k] = crc_a[k]; rzero[k] = zero_a[k];
               end
               ndone[k]++;
            end
         end
         @(negedge clk);
      end
   endtask

   task automatic expect_run(input int k, input logic md, input logic [31:0] erem,
                             input logic ezero, input string req);
      chk(req, "remainder", rrem[k], erem);
      chk(req, "zero flag", rzero[k], ezero);
      chk(req, "done latency", lat[k], md ? 1 : WA[k] + 1);
      chk("R9", "done pulse count", ndone[k], 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] m32, r16, r32, snap [3];
      logic [63:0] cw16, cw32;
      logic [63:0] errs [4];

      repeat (3) @(negedge clk);
      // R1: reset state
      for (int k = 0; k < 3; k++) begin
         chk("R1", "crc after reset", crc_a[k], 0);
         chk("R1", "done after reset", done_a[k], 0);
         chk("R1", "zero after reset", zero_a[k], 0);
      end
      rst_n = 1'b1;

      // R3 R4 R5: textbook vectors on the degree-4 generator
      for (int v = 0; v < 8; v++) begin
         run_msg(VECS[v].md, {48'b0, VECS[v].bits}, int'(VECS[v].len), 1'b0);
         expect_run(0, VECS[v].md, {28'b0, VECS[v].rem}, VECS[v].zero,
                    VECS[v].md ? "R5" : "R4");
      end

      // R2: start loads the starting value, then a restart mid-message
      @(negedge clk); start = 1'b1; mode = 1'b0;
      @(negedge clk); start = 1'b0;
      chk("R2", "init deg4", crc_a[0], 32'h0);
      chk("R2", "init 32-bit all ones", crc_a[2], 32'hFFFF_FFFF);
      chk("R2", "done cleared", done_a, 3'b000);
      for (int i = 0; i < 5; i++) begin
         valid = 1'b1; dbit = 1'b1; @(negedge clk);
      end
      valid = 1'b0;
      run_msg(1'b0, 64'b1011001, 7, 1'b0);
      expect_run(0, 1'b0, 32'hA, 1'b0, "R2");

      // R6: 16-bit and 32-bit generate, then check the codewords
      m32 = 32'hA5C3_1E77;
      run_msg(1'b0, {32'b0, m32}, 32, 1'b0);
      expect_run(1, 1'b0, ref_rem(1, {32'b0, m32}, 32, 1'b1), 1'b0, "R6");
      expect_run(2, 1'b0, ref_rem(2, {32'b0, m32}, 32, 1'b1), 1'b0, "R6");
      r16 = rrem[1];
      r32 = rrem[2];
      cw16 = {16'b0, m32, r16[15:0]};
      cw32 = {m32, r32};
      run_msg(1'b1, cw16, 48, 1'b0);
      expect_run(1, 1'b1, 32'h0, 1'b1, "R6");
      run_msg(1'b1, cw32, 64, 1'b0);
      expect_run(2, 1'b1, 32'h0, 1'b1, "R6");

      // R3: valid-low gaps do not change the result
      run_msg(1'b0, {32'b0, m32}, 32, 1'b1);
      chk("R3", "16-bit remainder with gaps", rrem[1], r16);
      chk("R3", "32-bit remainder with gaps", rrem[2], r32);

      // R7: error patterns on a 16-bit codeword
      errs[0] = 64'h1 << 5;
      errs[1] = (64'h1 << 3) | (64'h1 << 40);
      errs[2] = (64'h1 << 1) | (64'h1 << 20) | (64'h1 << 44);
      errs[3] = 64'hB38D << 15;
      for (int e = 0; e < 4; e++) begin
         run_msg(1'b1, cw16 ^ errs[e], 48, 1'b0);
         chk("R7", "corrupted codeword zero flag", rzero[1], 1'b0);
         chk("R7", "corrupted codeword done", ndone[1], 1);
      end

      // R8 R10: valid while idle is ignored and results hold
      for (int k = 0; k < 3; k++) snap[k] = crc_a[k];
      for (int i = 0; i < 6; i++) begin
         @(negedge clk); valid = 1'b1; dbit = i[0]; last = (i == 5);
         chk("R8", "no done while idle", done_a, 3'b000);
      end
      @(negedge clk); valid = 1'b0; last = 1'b0;
      repeat (8) @(negedge clk);
      for (int k = 0; k < 3; k++) begin
         chk("R8", "crc unchanged by idle bits", crc_a[k], snap[k]);
         chk("R10", "crc held after done", crc_a[k], snap[k]);
      end

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule